// File: doc/BRIEF.md
# Interrupt Event and Mask Register Bank

This block collects interrupt events for a reference-clock synchronizer. Clock monitors and the DPLL controller raise events such as a reference going away or coming back, the external reference losing or regaining activity, an automatic reference switch, a change of DPLL status, loss of signal and loss of lock. Each event sets a sticky flag in an eight-bit event register. Flags stay set until software reads that register. One read clears every flag at once.

A per-bit enable mask decides which flags drive the single active-high interrupt line. Flags are captured whether or not they are enabled, so software can poll events it has chosen not to be interrupted by. A change anywhere in the DPLL status vector raises the mode-change flag. In manual selection mode the loss-of-signal and loss-of-lock flags follow DPLL status bits 0 and 1 instead of the monitor pulses. So one failure of the active reference can raise several flags together.

Top module: `irq_event_bank`

## Requirements
- R1: After a synchronous active-low reset, all event flags are 0, the enable mask is 0, `irq` is 0 and `reg_rdata` is 0.
- R2: A one-cycle high pulse on an event input sets its flag, and the flag stays set until a clearing read. Flag bit positions at address 0x12 are: 0 `ref_down`, 1 `ref_up`, 2 `xref_quiet`, 3 `xref_alive`, 4 DPLL status change, 5 `ref_switch`, 6 loss of signal, 7 loss of lock.
- R3: A read (`reg_rd`) of address 0x12 returns the flags on `reg_rdata` one clock later and clears all flags together. An event that arrives in the same cycle as the clearing read is kept and appears on the next read.
- R4: Address 0x13 holds the enable mask, which can be written and read back. A write to 0x12 has no effect on the flags. A read of any other address returns 0.
- R5: `irq` is high one clock after any flag that is both set and enabled, and low one clock after no such flag remains. A flag whose enable bit is 0 is still captured.
- R6: Any change of `dpll_stat` from one cycle to the next sets flag 4.
- R7: With `manual_mode` high, flags 6 and 7 are set in every cycle in which `dpll_stat` bit 0 (for flag 6) or bit 1 (for flag 7) is high, and `los_evt` and `lol_evt` are ignored. With `manual_mode` low, flags 6 and 7 come from `los_evt` and `lol_evt`.
- R8: In manual mode, a rise of `dpll_stat` bit 0 sets flags 4 and 6 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_down | input | 1 | Pulse: a reference went from available to unavailable |
| ref_up | input | 1 | Pulse: a reference went from unavailable to available |
| xref_quiet | input | 1 | Pulse: the external reference lost activity |
| xref_alive | input | 1 | Pulse: the external reference regained activity |
| ref_switch | input | 1 | Pulse: the active reference was switched by automatic selection |
| los_evt | input | 1 | Pulse: loss of signal (automatic mode) |
| lol_evt | input | 1 | Pulse: loss of lock (automatic mode) |
| manual_mode | input | 1 | 1 = manual reference selection |
| dpll_stat | input | STAT_W | DPLL status vector; bit 0 loss of signal, bit 1 loss of lock |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| irq | output | 1 | Interrupt request, active high, registered |

## Verification
The bench builds the block with its defaults: an 8-bit address and data path, a 3-bit DPLL status vector, and the event and mask registers at 0x12 and 0x13. With the data width equal to the flag count, every flag and every mask bit can be seen in one read. With a 3-bit status vector, a change in a bit that does not feed a flag (bit 2) can be driven to show that the mode-change flag is raised on its own. The same vector also drives the mirrored loss-of-signal and loss-of-lock bits in manual mode.

// File: rtl/irq_bank_pkg.sv
// Package: shared constants for the interrupt event bank.
// Holds the flag count and the fixed bit position of each event source.
package irq_bank_pkg;
    localparam int EVT_COUNT      = 8;
    localparam int EVT_REF_DOWN   = 0;
    localparam int EVT_REF_UP     = 1;
    localparam int EVT_XREF_QUIET = 2;
    localparam int EVT_XREF_ALIVE = 3;
    localparam int EVT_STAT_CHG   = 4;
    localparam int EVT_SWITCH     = 5;
    localparam int EVT_LOS        = 6;
    localparam int EVT_LOL        = 7;

    typedef enum logic {SEL_AUTO = 1'b0, SEL_MANUAL = 1'b1} sel_mode_e;
endpackage

// File: rtl/irq_src_map.sv
// Module: irq_src_map
// Builds the per-cycle set vector from the monitor pulses and the DPLL status.
// Assumes: pulses are synchronous to clk; dpll_stat has at least two bits.
module irq_src_map
    import irq_bank_pkg::*;
#(
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_down,
    input  logic              ref_up,
    input  logic              xref_quiet,
    input  logic              xref_alive,
    input  logic              ref_switch,
    input  logic              los_evt,
    input  logic              lol_evt,
    input  logic              manual_mode,
    input  logic [STAT_W-1:0] dpll_stat,
    output logic [EVT_COUNT-1:0] set_vec
);
    logic [STAT_W-1:0] stat_q;
    sel_mode_e         mode;

    assign mode = sel_mode_e'(manual_mode);

    // Keep last cycle's status; during reset follow the input so release raises nothing.
    always_ff @(posedge clk) begin
        stat_q <= dpll_stat;
    end

    // Map each source onto its fixed flag position.
    always_comb begin
        set_vec                 = '0;
        set_vec[EVT_REF_DOWN]   = ref_down;
        set_vec[EVT_REF_UP]     = ref_up;
        set_vec[EVT_XREF_QUIET] = xref_quiet;
        set_vec[EVT_XREF_ALIVE] = xref_alive;
        set_vec[EVT_STAT_CHG]   = rst_n && (dpll_stat != stat_q);
        set_vec[EVT_SWITCH]     = ref_switch;
        if (mode == SEL_MANUAL) begin
            set_vec[EVT_LOS] = dpll_stat[0];
            set_vec[EVT_LOL] = dpll_stat[1];
        end else begin
            set_vec[EVT_LOS] = los_evt;
            set_vec[EVT_LOL] = lol_evt;
        end
    end
endmodule

// File: rtl/irq_flag_reg.sv
// Module: irq_flag_reg
// Sticky event flags: set by set_vec, cleared together by clr. Set wins over clear.
// Assumes: clr is a single-cycle strobe from the register port.
module irq_flag_reg
    import irq_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_COUNT-1:0] set_vec,
    input  logic                 clr,
    output logic [EVT_COUNT-1:0] flags
);
    // Hold, clear on read, and merge new events so none is lost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (clr ? '0 : flags) | set_vec;
        end
    end

    generate
        for (genvar i = 0; i < EVT_COUNT; i++) begin : g_sticky
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && !clr) |=> flags[i]);  // R2
        end
    endgenerate

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec == '0) |=> (flags == '0));  // R3
endmodule

// File: rtl/irq_reg_port.sv
// Module: irq_reg_port
// Register decode: event register (read clears), enable mask (read/write).
// Assumes: reg_rd and reg_wr are never high in the same cycle for the same address.
module irq_reg_port
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter logic [ADDR_W-1:0] EVT_ADDR  = 8'h12,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [EVT_COUNT-1:0] flags,
    output logic [EVT_COUNT-1:0] mask,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 clr
);
    logic hit_evt, hit_mask;

    assign hit_evt  = (reg_addr == EVT_ADDR);
    assign hit_mask = (reg_addr == MASK_ADDR);
    assign clr      = reg_rd && hit_evt;

    // Enable mask: written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (reg_wr && hit_mask) begin
            mask <= reg_wdata[EVT_COUNT-1:0];
        end
    end

    // Read data: captured on a read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (hit_evt)       reg_rdata <= DATA_W'(flags);
            else if (hit_mask) reg_rdata <= DATA_W'(mask);
            else               reg_rdata <= '0;
        end
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit_mask) |=> $stable(mask));  // R4
endmodule

// File: rtl/irq_event_bank.sv
// Module: irq_event_bank (top)
// Interrupt collector: sticky flags, enable mask, registered interrupt line.
// Assumes: all inputs synchronous to clk; DATA_W >= flag count; STAT_W >= 2.
module irq_event_bank
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int STAT_W    = 3,
    parameter logic [ADDR_W-1:0] EVT_ADDR  = 8'h12,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_down,
    input  logic              ref_up,
    input  logic              xref_quiet,
    input  logic              xref_alive,
    input  logic              ref_switch,
    input  logic              los_evt,
    input  logic              lol_evt,
    input  logic              manual_mode,
    input  logic [STAT_W-1:0] dpll_stat,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [EVT_COUNT-1:0] set_vec, flags, mask;
    logic                 clr;

    irq_src_map #(.STAT_W(STAT_W)) u_src (
        .clk(clk), .rst_n(rst_n),
        .ref_down(ref_down), .ref_up(ref_up),
        .xref_quiet(xref_quiet), .xref_alive(xref_alive),
        .ref_switch(ref_switch), .los_evt(los_evt), .lol_evt(lol_evt),
        .manual_mode(manual_mode), .dpll_stat(dpll_stat),
        .set_vec(set_vec)
    );

    irq_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(clr), .flags(flags)
    );

    irq_reg_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .EVT_ADDR(EVT_ADDR), .MASK_ADDR(MASK_ADDR)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flags(flags),
        .mask(mask), .reg_rdata(reg_rdata), .clr(clr)
    );

    // Interrupt line: registered OR of enabled flags, free of decode glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flags & mask);
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask) != '0) |=> irq);  // R5
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask) == '0) |=> !irq);  // R5
    AST_STAT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dpll_stat != $past(dpll_stat)) |=> flags[EVT_STAT_CHG]);  // R6
endmodule

// File: tb/irq_event_bank_test.sv
// Bench for irq_event_bank: a vector table walked by one loop, then directed cases.
module irq_event_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_down = 0, ref_up = 0, xref_quiet = 0, xref_alive = 0;
    logic       ref_switch = 0, los_evt = 0, lol_evt = 0, manual_mode = 0;
    logic [2:0] dpll_stat = '0;
    logic       reg_rd = 0, reg_wr = 0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] rd_val;

    always #5 clk = ~clk;

    irq_event_bank uut (
        .clk(clk), .rst_n(rst_n), .ref_down(ref_down), .ref_up(ref_up),
        .xref_quiet(xref_quiet), .xref_alive(xref_alive), .ref_switch(ref_switch),
        .los_evt(los_evt), .lol_evt(lol_evt), .manual_mode(manual_mode),
        .dpll_stat(dpll_stat), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {manual, pulses[7:0], stat[2:0], mask[7:0], expected read[7:0], expected irq}
    localparam logic [28:0] VECS [10] = '{
        {1'b0, 8'h01, 3'b000, 8'hFF, 8'h01, 1'b1},  // R2 ref_down
        {1'b0, 8'h02, 3'b000, 8'h00, 8'h02, 1'b0},  // R5 masked, still captured
        {1'b0, 8'h0C, 3'b000, 8'h04, 8'h0C, 1'b1},  // R2 activity pair
        {1'b0, 8'h20, 3'b000, 8'h10, 8'h20, 1'b0},  // R5 other bit enabled
        {1'b0, 8'hC0, 3'b000, 8'h80, 8'hC0, 1'b1},  // R7 auto los/lol pulses
        {1'b0, 8'h00, 3'b100, 8'h10, 8'h10, 1'b1},  // R6 status change only
        {1'b1, 8'h00, 3'b001, 8'h40, 8'h50, 1'b1},  // R8 manual loss of signal
        {1'b1, 8'hC0, 3'b000, 8'hFF, 8'h00, 1'b0},  // R7 manual ignores pulses
        {1'b1, 8'h00, 3'b010, 8'h80, 8'h90, 1'b1},  // R7 manual loss of lock
        {1'b0, 8'hEF, 3'b000, 8'hFF, 8'hEF, 1'b1}   // R2 all pulse sources
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
        reg_rd = 1; reg_addr = a;
        step();
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic drive_pulses(input logic [7:0] p);
        ref_down = p[0]; ref_up = p[1]; xref_quiet = p[2]; xref_alive = p[3];
        ref_switch = p[5]; los_evt = p[6]; lol_evt = p[7];
    endtask

    task automatic flush();
        manual_mode = 0; dpll_stat = '0;
        step(); step();
        read_reg(8'h12, rd_val);
        step();
    endtask

    initial begin
        #1_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        // R1 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 rdata", reg_rdata, 8'h00);
        read_reg(8'h13, rd_val);
        check("R1 mask", rd_val, 8'h00);
        read_reg(8'h12, rd_val);
        check("R1 flags", rd_val, 8'h00);

        for (int i = 0; i < 10; i++) begin
            write_reg(8'h13, VECS[i][16:9]);
            manual_mode = VECS[i][28];
            drive_pulses(VECS[i][27:20]);
            dpll_stat = VECS[i][19:17];
            step();
            drive_pulses(8'h00);
            step();
            check($sformatf("R5 vec%0d irq", i), {7'b0, irq}, {7'b0, VECS[i][0]});
            read_reg(8'h12, rd_val);
            check($sformatf("R2 vec%0d read", i), rd_val, VECS[i][8:1]);
            flush();
        end

        // R4 mask readback, write to event register ignored, unmapped reads zero
        write_reg(8'h13, 8'hA5);
        read_reg(8'h13, rd_val);
        check("R4 mask readback", rd_val, 8'hA5);
        write_reg(8'h12, 8'hFF);
        step();
        read_reg(8'h12, rd_val);
        check("R4 event write ignored", rd_val, 8'h00);
        check("R4 irq after event write", {7'b0, irq}, 8'h00);
        read_reg(8'h14, rd_val);
        check("R4 unmapped read", rd_val, 8'h00);

        // R3 event in the same cycle as the clearing read survives
        write_reg(8'h13, 8'hFF);
        drive_pulses(8'h01);
        step();
        drive_pulses(8'h02);
        read_reg(8'h12, rd_val);
        drive_pulses(8'h00);
        check("R3 first read", rd_val, 8'h01);
        read_reg(8'h12, rd_val);
        check("R3 kept event", rd_val, 8'h02);
        read_reg(8'h12, rd_val);
        check("R3 cleared", rd_val, 8'h00);

        // R5 irq drops one clock after the clearing read
        drive_pulses(8'h08);
        step();
        drive_pulses(8'h00);
        step();
        check("R5 irq high", {7'b0, irq}, 8'h01);
        read_reg(8'h12, rd_val);
        step();
        check("R5 irq low after clear", {7'b0, irq}, 8'h00);

        // R7 manual mirror re-sets flag 6 while status bit 0 stays high; R8 first read
        manual_mode = 1; dpll_stat = 3'b001;
        step(); step();
        read_reg(8'h12, rd_val);
        check("R8 manual los read", rd_val, 8'h50);
        step();
        read_reg(8'h12, rd_val);
        check("R7 mirror level", rd_val, 8'h40);
        flush();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule